// File: doc/BRIEF.md
# SCSI Command Descriptor Decoder

This block sits behind a SCSI initiator's selection logic. During a select-with-attention, the selection logic forwards the outgoing bytes to it one per clock on a valid/last stream. The first byte is the identify message. The bytes after it form the command descriptor block. When the last byte arrives, the decoder checks the addressed target against an upper bound and a presence mask. It then classifies the opcode and reports five results:

- the data-phase direction;
- the transfer byte count;
- the block address and block count for the ten-byte read and write commands;
- the status, interrupt and sequence-step codes for the host;
- a one-cycle done pulse.

The decoded results hold until the next one replaces them.

For the two commands that the block answers from its own knowledge, inquiry and read capacity, it can stream the fixed response bytes to a data mover. It presents one byte at a time under a valid/request handshake and flags the final byte. A new selection sequence cancels any response that has not been fully read.

Top module: `scsi_cdb_decoder`

## Requirements
- R1: A target number above 4, or a target whose bit in `present_mask` is 0, ends the decode with status 0x80, interrupt 0x20, sequence step 0, transfer length 0, direction host-to-device (`dir_in`=0), and block address and block count 0.
- R2: Every decode that finds its target present ends with status 0x91, interrupt 0x18 and sequence step 4, whatever the opcode.
- R3: Opcode 0x12 (inquiry) gives `dir_in`=1 and a transfer length of 36.
- R4: Opcode 0x25 (read capacity) gives `dir_in`=1 and a transfer length of 8.
- R5: Opcode 0x28 gives `dir_in`=1 and opcode 0x2A gives `dir_in`=0. For both, the block address is the big-endian word at sequence indices 3..6 and the block count is the big-endian half-word at indices 8..9. The transfer length is the block count times 512, carried as 25 bits.
- R6: Opcodes 0x00, 0x1A and every opcode not named in R3–R5 give transfer length 0, `dir_in`=0, and block address and block count 0.
- R7: Sequence index 0 is the message byte and index 1 is the opcode. A sequence that ends before a field is complete reads every byte it did not deliver as 0, even if an earlier sequence delivered that byte. Bytes past index 9 are ignored.
- R8: `done` is high for exactly the one cycle that starts two rising edges after the edge that accepts the last byte. The decoded outputs change only on that edge and hold until the next decode.
- R9: After an inquiry decode for a present target, the response stream carries 36 bytes. Byte 0 is 5 when the target's bit in `optical_mask` is set and 0 otherwise. Byte 2 is 1, byte 3 is 2, and every other byte is 0.
- R10: After a read-capacity decode, the response stream carries 8 bytes: `cap_sectors` big-endian in bytes 0..3, then 0x00, 0x00, 0x02, 0x00.
- R11: A response byte is consumed on each rising edge where `rsp_valid` and `rsp_req` are both high. `rsp_last` marks the final byte. `rsp_valid` stays high while `rsp_req` is low. The first byte of a new sequence drops `rsp_valid` from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sequence byte is present on `in_byte` |
| in_byte | input | 8 | Sequence byte |
| in_last | input | 1 | This byte ends the sequence |
| target_id | input | 3 | Addressed target, sampled when decoding |
| present_mask | input | 8 | One bit per target number: device attached |
| optical_mask | input | 8 | One bit per target number: optical device |
| cap_sectors | input | 32 | Sector count reported by read capacity |
| done | output | 1 | One-cycle decode-complete pulse |
| dir_in | output | 1 | 1 = device-to-host data phase |
| xfer_len | output | 25 | Data-phase byte count |
| lba | output | 32 | Block address |
| blk_cnt | output | 16 | Block count |
| status | output | 8 | Status code |
| intr | output | 8 | Interrupt cause code |
| seq_step | output | 3 | Sequence step |
| rsp_req | input | 1 | Consumer takes the presented response byte |
| rsp_valid | output | 1 | A response byte is presented |
| rsp_byte | output | 8 | Response byte |
| rsp_last | output | 1 | The presented byte is the final one |

## Verification
Some properties are checked by assertions on every cycle:

- the absent-target and success code sets are consistent with the transfer length;
- a host-to-device length is always a whole number of blocks;
- outputs stay stable between done pulses;
- done follows an accepted last byte by exactly two edges;
- the response stream ends on its final byte and never flags a last byte without a valid one.

Other behaviour only the directed scenarios can show: the opcode-to-direction mapping, the exact block address and count taken from their byte positions, zero-fill of a short or reused sequence, the response byte contents for each device type, and the cancellation of a partly read response by a new selection.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    localparam logic [7:0] OPC_TUR       = 8'h00;
    localparam logic [7:0] OPC_INQUIRY   = 8'h12;
    localparam logic [7:0] OPC_MODESENSE = 8'h1A;
    localparam logic [7:0] OPC_READCAP   = 8'h25;
    localparam logic [7:0] OPC_READ10    = 8'h28;
    localparam logic [7:0] OPC_WRITE10   = 8'h2A;

    localparam logic [7:0] STS_OK     = 8'h91;
    localparam logic [7:0] STS_ABSENT = 8'h80;
    localparam logic [7:0] INT_OK     = 8'h18;
    localparam logic [7:0] INT_DISC   = 8'h20;
    localparam logic [2:0] STEP_OK    = 3'd4;
    localparam logic [2:0] STEP_NONE  = 3'd0;

    localparam int INQ_LEN = 36;
    localparam int CAP_LEN = 8;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_INQ  = 2'd1,
        RSP_CAP  = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/cdb_capture.sv
module cdb_capture #(
    parameter int DEPTH = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    input  logic                  in_last,
    output logic                  seq_start,
    output logic                  complete,
    output logic [DEPTH-1:0][7:0] bytes
);
    localparam int IDX_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                  busy;
        logic [IDX_W-1:0]      idx;
        logic                  cmp;
        logic [DEPTH-1:0][7:0] mem;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.cmp = 1'b0;
        seq_start = in_valid && !cap_q.busy;
        if (in_valid) begin
            if (!cap_q.busy) begin
                cap_d.mem    = '0;
                cap_d.mem[0] = in_byte;
                cap_d.idx    = IDX_W'(1);
            end else if (cap_q.idx < IDX_W'(DEPTH)) begin
                cap_d.mem[cap_q.idx] = in_byte;
                cap_d.idx            = cap_q.idx + IDX_W'(1);
            end
            cap_d.busy = !in_last;
            cap_d.cmp  = in_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign complete = cap_q.cmp;
    assign bytes    = cap_q.mem;

    assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.idx <= IDX_W'(DEPTH));

    assert_busy_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> !cap_q.busy && complete);

endmodule

// File: rtl/cdb_decode.sv
module cdb_decode
    import cdb_pkg::*;
#(
    parameter int TGT_W     = 3,
    parameter int MAX_TGT   = 4,
    parameter int DEPTH     = 10,
    parameter int CNT_W     = 16,
    parameter int BLK_SHIFT = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      complete,
    input  logic [DEPTH-1:0][7:0]     bytes,
    input  logic [TGT_W-1:0]          target_id,
    input  logic [(1<<TGT_W)-1:0]     present_mask,
    input  logic [(1<<TGT_W)-1:0]     optical_mask,
    input  logic [31:0]               cap_sectors,
    output logic                      done,
    output logic                      dir_in,
    output logic [CNT_W+BLK_SHIFT-1:0] xfer_len,
    output logic [31:0]               lba,
    output logic [CNT_W-1:0]          blk_cnt,
    output logic [7:0]                status,
    output logic [7:0]                intr,
    output logic [2:0]                seq_step,
    output rsp_kind_e                 rsp_kind,
    output logic                      rsp_optical,
    output logic [31:0]               rsp_sectors
);
    localparam int XLEN_W = CNT_W + BLK_SHIFT;

    typedef struct packed {
        logic              done;
        logic              dir_in;
        logic [XLEN_W-1:0] xlen;
        logic [31:0]       lba;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        status;
        logic [7:0]        intr;
        logic [2:0]        step;
        rsp_kind_e         kind;
        logic              optical;
        logic [31:0]       sectors;
    } res_t;

    res_t res_d, res_q;
    logic       found;
    logic [7:0] opcode;
    logic [31:0] f_lba;
    logic [CNT_W-1:0] f_cnt;

    always_comb begin
        found  = (target_id <= TGT_W'(MAX_TGT)) && present_mask[target_id];
        opcode = bytes[1];
        f_lba  = {bytes[3], bytes[4], bytes[5], bytes[6]};
        f_cnt  = CNT_W'({bytes[8], bytes[9]});

        res_d      = res_q;
        res_d.done = 1'b0;
        if (complete) begin
            res_d.done    = 1'b1;
            res_d.dir_in  = 1'b0;
            res_d.xlen    = '0;
            res_d.lba     = '0;
            res_d.cnt     = '0;
            res_d.kind    = RSP_NONE;
            res_d.optical = optical_mask[target_id];
            res_d.sectors = cap_sectors;
            if (!found) begin
                res_d.status = STS_ABSENT;
                res_d.intr   = INT_DISC;
                res_d.step   = STEP_NONE;
            end else begin
                res_d.status = STS_OK;
                res_d.intr   = INT_OK;
                res_d.step   = STEP_OK;
                case (opcode)
                    OPC_INQUIRY: begin
                        res_d.dir_in = 1'b1;
                        res_d.xlen   = XLEN_W'(INQ_LEN);
                        res_d.kind   = RSP_INQ;
                    end
                    OPC_READCAP: begin
                        res_d.dir_in = 1'b1;
                        res_d.xlen   = XLEN_W'(CAP_LEN);
                        res_d.kind   = RSP_CAP;
                    end
                    OPC_READ10, OPC_WRITE10: begin
                        res_d.dir_in = (opcode == OPC_READ10);
                        res_d.lba    = f_lba;
                        res_d.cnt    = f_cnt;
                        res_d.xlen   = {f_cnt, {BLK_SHIFT{1'b0}}};
                    end
                    default: begin
                        res_d.dir_in = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done        = res_q.done;
    assign dir_in      = res_q.dir_in;
    assign xfer_len    = res_q.xlen;
    assign lba         = res_q.lba;
    assign blk_cnt     = res_q.cnt;
    assign status      = res_q.status;
    assign intr        = res_q.intr;
    assign seq_step    = res_q.step;
    assign rsp_kind    = res_q.kind;
    assign rsp_optical = res_q.optical;
    assign rsp_sectors = res_q.sectors;

    assert_absent_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == STS_ABSENT) |-> (xfer_len == '0 && intr == INT_DISC
                                            && seq_step == STEP_NONE && !dir_in));

    assert_success_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == STS_OK) |-> (intr == INT_OK && seq_step == STEP_OK));

    assert_out_len_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_in |-> (xfer_len[BLK_SHIFT-1:0] == '0));

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(xfer_len) && $stable(status) && $stable(lba)
                   && $stable(dir_in) && $stable(blk_cnt)));

endmodule

// File: rtl/cdb_resp_gen.sv
module cdb_resp_gen
    import cdb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  rsp_kind_e   kind,
    input  logic        optical,
    input  logic [31:0] sectors,
    input  logic        abort,
    input  logic        rsp_req,
    output logic        rsp_valid,
    output logic [7:0]  rsp_byte,
    output logic        rsp_last
);
    localparam int IDX_W = $clog2(INQ_LEN);

    typedef struct packed {
        logic             active;
        rsp_kind_e        kind;
        logic [IDX_W-1:0] idx;
        logic             optical;
        logic [31:0]      sectors;
    } gen_t;

    gen_t g_d, g_q;
    logic [IDX_W-1:0] final_idx;

    always_comb begin
        final_idx = (g_q.kind == RSP_INQ) ? IDX_W'(INQ_LEN - 1) : IDX_W'(CAP_LEN - 1);
        rsp_valid = g_q.active;
        rsp_last  = g_q.active && (g_q.idx == final_idx);

        rsp_byte = 8'h00;
        if (g_q.kind == RSP_INQ) begin
            case (g_q.idx)
                IDX_W'(0): rsp_byte = g_q.optical ? 8'h05 : 8'h00;
                IDX_W'(2): rsp_byte = 8'h01;
                IDX_W'(3): rsp_byte = 8'h02;
                default:   rsp_byte = 8'h00;
            endcase
        end else if (g_q.kind == RSP_CAP) begin
            case (g_q.idx)
                IDX_W'(0): rsp_byte = g_q.sectors[31:24];
                IDX_W'(1): rsp_byte = g_q.sectors[23:16];
                IDX_W'(2): rsp_byte = g_q.sectors[15:8];
                IDX_W'(3): rsp_byte = g_q.sectors[7:0];
                IDX_W'(6): rsp_byte = 8'h02;
                default:   rsp_byte = 8'h00;
            endcase
        end

        g_d = g_q;
        if (abort) begin
            g_d.active = 1'b0;
        end else if (load) begin
            g_d.active  = (kind != RSP_NONE);
            g_d.kind    = kind;
            g_d.idx     = '0;
            g_d.optical = optical;
            g_d.sectors = sectors;
        end else if (g_q.active && rsp_req) begin
            if (rsp_last) g_d.active = 1'b0;
            else          g_d.idx    = g_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assert_last_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_req && rsp_last && !load && !abort) |=> !rsp_valid);

    assert_last_has_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    assert_abort_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !rsp_valid);

endmodule

// File: rtl/scsi_cdb_decoder.sv
module scsi_cdb_decoder
    import cdb_pkg::*;
#(
    parameter int TGT_W     = 3,
    parameter int MAX_TGT   = 4,
    parameter int DEPTH     = 10,
    parameter int CNT_W     = 16,
    parameter int BLK_SHIFT = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [7:0]                 in_byte,
    input  logic                       in_last,
    input  logic [TGT_W-1:0]           target_id,
    input  logic [(1<<TGT_W)-1:0]      present_mask,
    input  logic [(1<<TGT_W)-1:0]      optical_mask,
    input  logic [31:0]                cap_sectors,
    output logic                       done,
    output logic                       dir_in,
    output logic [CNT_W+BLK_SHIFT-1:0] xfer_len,
    output logic [31:0]                lba,
    output logic [CNT_W-1:0]           blk_cnt,
    output logic [7:0]                 status,
    output logic [7:0]                 intr,
    output logic [2:0]                 seq_step,
    input  logic                       rsp_req,
    output logic                       rsp_valid,
    output logic [7:0]                 rsp_byte,
    output logic                       rsp_last
);
    logic                  seq_start;
    logic                  complete;
    logic [DEPTH-1:0][7:0] bytes;
    rsp_kind_e             rsp_kind;
    logic                  rsp_optical;
    logic [31:0]           rsp_sectors;

    cdb_capture #(.DEPTH(DEPTH)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_last   (in_last),
        .seq_start (seq_start),
        .complete  (complete),
        .bytes     (bytes)
    );

    cdb_decode #(
        .TGT_W(TGT_W), .MAX_TGT(MAX_TGT), .DEPTH(DEPTH),
        .CNT_W(CNT_W), .BLK_SHIFT(BLK_SHIFT)
    ) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .complete     (complete),
        .bytes        (bytes),
        .target_id    (target_id),
        .present_mask (present_mask),
        .optical_mask (optical_mask),
        .cap_sectors  (cap_sectors),
        .done         (done),
        .dir_in       (dir_in),
        .xfer_len     (xfer_len),
        .lba          (lba),
        .blk_cnt      (blk_cnt),
        .status       (status),
        .intr         (intr),
        .seq_step     (seq_step),
        .rsp_kind     (rsp_kind),
        .rsp_optical  (rsp_optical),
        .rsp_sectors  (rsp_sectors)
    );

    cdb_resp_gen u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .kind      (rsp_kind),
        .optical   (rsp_optical),
        .sectors   (rsp_sectors),
        .abort     (seq_start),
        .rsp_req   (rsp_req),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte),
        .rsp_last  (rsp_last)
    );

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_last, 2));

endmodule

// File: tb/scsi_cdb_decoder_tb.sv
module scsi_cdb_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_last = 1'b0;
    logic [2:0]  target_id = 3'd0;
    logic [7:0]  present_mask = 8'b0010_1111;
    logic [7:0]  optical_mask = 8'b0000_0010;
    logic [31:0] cap_sectors = 32'h0012ABCD;
    logic        done, dir_in;
    logic [24:0] xfer_len;
    logic [31:0] lba;
    logic [15:0] blk_cnt;
    logic [7:0]  status, intr;
    logic [2:0]  seq_step;
    logic        rsp_req = 1'b0;
    logic        rsp_valid, rsp_last;
    logic [7:0]  rsp_byte;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    logic [7:0] sb [0:15];
    logic [7:0] rb [0:35];

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_cdb_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .target_id(target_id), .present_mask(present_mask),
        .optical_mask(optical_mask), .cap_sectors(cap_sectors), .done(done),
        .dir_in(dir_in), .xfer_len(xfer_len), .lba(lba), .blk_cnt(blk_cnt),
        .status(status), .intr(intr), .seq_step(seq_step), .rsp_req(rsp_req),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_last(rsp_last)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_seq(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7, b8, b9);
        sb[0] = b0; sb[1] = b1; sb[2] = b2; sb[3] = b3; sb[4] = b4;
        sb[5] = b5; sb[6] = b6; sb[7] = b7; sb[8] = b8; sb[9] = b9;
        for (int i = 10; i < 16; i++) sb[i] = 8'hEE;
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = sb[i];
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // sends n bytes, checks done timing and all decoded fields, then hold
    task automatic decode(input string req, input int n, input logic [2:0] tgt,
                          input logic exp_dir, input logic [24:0] exp_len,
                          input logic [31:0] exp_lba, input logic [15:0] exp_cnt,
                          input logic exp_ok);
        target_id = tgt;
        send(n);
        chk("R8", "done early", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R8", "done pulse", {31'd0, done}, 32'd1);
        chk(req, "dir_in", {31'd0, dir_in}, {31'd0, exp_dir});
        chk(req, "xfer_len", {7'd0, xfer_len}, {7'd0, exp_len});
        chk(req, "lba", lba, exp_lba);
        chk(req, "blk_cnt", {16'd0, blk_cnt}, {16'd0, exp_cnt});
        if (exp_ok) begin
            chk("R2", "status", {24'd0, status}, 32'h91);
            chk("R2", "intr", {24'd0, intr}, 32'h18);
            chk("R2", "seq_step", {29'd0, seq_step}, 32'd4);
        end else begin
            chk("R1", "status", {24'd0, status}, 32'h80);
            chk("R1", "intr", {24'd0, intr}, 32'h20);
            chk("R1", "seq_step", {29'd0, seq_step}, 32'd0);
        end
        @(negedge clk);
        chk("R8", "done one cycle", {31'd0, done}, 32'd0);
        chk("R8", "len held", {7'd0, xfer_len}, {7'd0, exp_len});
    endtask

    task automatic read_rsp(input string req, input int total, input int upto);
        for (int k = 0; k < upto; k++) begin
            chk("R11", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
            chk(req, $sformatf("rsp_byte[%0d]", k), {24'd0, rsp_byte}, {24'd0, rb[k]});
            chk("R11", "rsp_last", {31'd0, rsp_last}, {31'd0, (k == total - 1)});
            rsp_req = 1'b1;
            @(negedge clk);
        end
        rsp_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8", "reset done", {31'd0, done}, 32'd0);
        chk("R8", "reset status", {24'd0, status}, 32'd0);
        chk("R11", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_inquiry_optical();
        set_seq(8'hC0, 8'h12, 0, 0, 36, 0, 0, 0, 0, 0);
        decode("R3", 6, 3'd1, 1'b1, 25'd36, 32'd0, 16'd0, 1'b1);
        for (int i = 0; i < 36; i++) rb[i] = 8'h00;
        rb[0] = 8'h05; rb[2] = 8'h01; rb[3] = 8'h02;
        read_rsp("R9", 36, 36);
        chk("R11", "valid after last", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_inquiry_disk_abort();
        set_seq(8'hC0, 8'h12, 0, 0, 36, 0, 0, 0, 0, 0);
        decode("R3", 6, 3'd0, 1'b1, 25'd36, 32'd0, 16'd0, 1'b1);
        for (int i = 0; i < 36; i++) rb[i] = 8'h00;
        rb[2] = 8'h01; rb[3] = 8'h02;
        read_rsp("R9", 36, 3);
        @(negedge clk);
        chk("R11", "valid held without req", {31'd0, rsp_valid}, 32'd1);
        chk("R9", "byte 3 held", {24'd0, rsp_byte}, 32'h02);
        set_seq(8'hC0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        target_id = 3'd0;
        send(1);
        chk("R11", "abort by new seq", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        chk("R7", "single byte = opcode 0 len", {7'd0, xfer_len}, 32'd0);
        chk("R2", "single byte status", {24'd0, status}, 32'h91);
    endtask

    task automatic t_capacity();
        set_seq(8'hC0, 8'h25, 0, 0, 0, 0, 0, 0, 0, 0);
        decode("R4", 11, 3'd2, 1'b1, 25'd8, 32'd0, 16'd0, 1'b1);
        rb[0] = 8'h00; rb[1] = 8'h12; rb[2] = 8'hAB; rb[3] = 8'hCD;
        rb[4] = 8'h00; rb[5] = 8'h00; rb[6] = 8'h02; rb[7] = 8'h00;
        read_rsp("R10", 8, 8);
        chk("R11", "valid after cap", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_read_write();
        set_seq(8'hC0, 8'h28, 0, 8'h01, 8'h02, 8'h03, 8'h04, 0, 8'h00, 8'h10);
        decode("R5", 10, 3'd3, 1'b1, 25'h0002000, 32'h01020304, 16'h0010, 1'b1);
        set_seq(8'hC1, 8'h2A, 0, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 0, 8'hFF, 8'hFF);
        decode("R5", 10, 3'd1, 1'b0, 25'h1FFFE00, 32'hDEADBEEF, 16'hFFFF, 1'b1);
        // short read after full write: stale bytes must read as zero
        set_seq(8'hC0, 8'h28, 0, 8'h11, 0, 0, 0, 0, 0, 0);
        decode("R7", 4, 3'd3, 1'b1, 25'd0, 32'h11000000, 16'd0, 1'b1);
    endtask

    task automatic t_no_data();
        set_seq(8'hC0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
        decode("R6", 6, 3'd0, 1'b0, 25'd0, 32'd0, 16'd0, 1'b1);
        set_seq(8'hC0, 8'h1A, 0, 8'h3F, 0, 8'hFF, 0, 0, 0, 0);
        decode("R6", 6, 3'd2, 1'b0, 25'd0, 32'd0, 16'd0, 1'b1);
        set_seq(8'hC0, 8'h55, 0, 8'h01, 8'h02, 8'h03, 8'h04, 0, 8'h01, 8'h00);
        decode("R6", 10, 3'd3, 1'b0, 25'd0, 32'd0, 16'd0, 1'b1);
        chk("R6", "no response stream", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_absent();
        set_seq(8'hC0, 8'h28, 0, 8'h01, 8'h02, 8'h03, 8'h04, 0, 8'h00, 8'h10);
        decode("R1", 10, 3'd5, 1'b0, 25'd0, 32'd0, 16'd0, 1'b0);
        set_seq(8'hC0, 8'h12, 0, 0, 36, 0, 0, 0, 0, 0);
        decode("R1", 6, 3'd4, 1'b0, 25'd0, 32'd0, 16'd0, 1'b0);
        chk("R1", "absent no response", {31'd0, rsp_valid}, 32'd0);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inquiry_optical();
        t_inquiry_disk_abort();
        t_capacity();
        t_read_write();
        t_no_data();
        t_absent();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule